// File: doc/BRIEF.md
# USB Endpoint Control and Response Selector

This block keeps one 8-bit control word for each of sixteen device endpoints and uses those words to decide how the device answers an incoming token. Software reads and writes the control words through a small word-indexed register port. The packet engine presents a token event that carries the endpoint number, the token kind and a flag saying whether data is ready. Two clock edges later the block returns a one-cycle response code. The packet engine then uses that code to send STALL, to go ahead with the transfer and acknowledge it, to send NAK, to go ahead without a handshake, or to stay silent.

The control word uses these bits. Bit 7 is low-speed direct-attach and bit 6 is retry-inhibit; both exist on endpoint 0 only. Bit 5 is reserved. Bit 4 is setup-block. Bit 3 is receive-enable and bit 2 is transmit-enable. Bit 1 is halt. Bit 0 is handshake-enable. The response is chosen in a fixed priority order. Halt wins only while a direction is enabled. Setup-block then applies only when both directions are enabled. After that the direction gate applies, and then the handshake rules.

A two-state machine sequences each token. In ST_IDLE, a token (tok_valid high) is captured and the machine takes the transition IDLE_TO_EVAL. In ST_EVAL, the captured endpoint's control word is looked up, the response is registered, and the machine always takes the transition EVAL_TO_IDLE. Tokens presented while the machine is in ST_EVAL are dropped.

Top module: `usbep_ctrl`

## Requirements
- R1: After reset every control word reads 8'h00 and rsp_valid is 0.
- R2: Bit 5 of every control word reads 0 and ignores writes. Bits 7 and 6 are stored only for endpoint 0; for endpoints 1 to 15 they read 0 whatever is written.
- R3: A write with reg_wr high stores reg_wdata into the word selected by reg_sel at the clock edge. reg_rdata combinationally shows the word selected by reg_sel. Other words are unchanged.
- R4: When halt (bit 1) is set and bit 3 or bit 2 is set, every token to that endpoint gets response code 3 (STALL), regardless of the other bits.
- R5: When halt is set but bits 3 and 2 are both clear, halt has no effect, and a token gets code 0 (ignore).
- R6: When setup-block (bit 4) is set with both bits 3 and 2 set, a SETUP token (tok_kind 2) gets code 0. With only one direction enabled, setup-block has no effect.
- R7: An IN token (tok_kind 1) needs transmit-enable (bit 2). OUT (tok_kind 0) and SETUP tokens need receive-enable (bit 3). If the needed bit is clear, or tok_kind is 3, the code is 0.
- R8: On an accepted token with handshake-enable (bit 0) clear, the code is 4 (no handshake), whatever tok_data_rdy is.
- R9: On an accepted token with handshake-enable set, the code is 1 (ACK-eligible) when tok_data_rdy is 1 and 2 (NAK) when it is 0.
- R10: A token sampled in ST_IDLE produces rsp_valid high for exactly one cycle, two rising edges later. A token presented while the machine is in ST_EVAL is dropped.
- R11: Halt stays set across any number of tokens until software rewrites the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Endpoint word select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected word |
| tok_valid | input | 1 | Token event strobe |
| tok_ep | input | 4 | Token endpoint number |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| tok_data_rdy | input | 1 | Data ready for the transfer |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 3 | 0 ignore, 1 ACK-eligible, 2 NAK, 3 STALL, 4 no handshake |

## Verification
The latency and single-pulse properties assume that tok_valid is not held high into the cycle after a capture, unless dropping a token is the intent. The bench holds a token for exactly one cycle, except in the one scenario that deliberately presents a second token while the machine is in ST_EVAL. The write-readback property assumes that reg_sel stays put for the cycle after a write. The bench writes and then reads back through the same select value, and moves the select only between accesses.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_t;

    typedef enum logic [2:0] {
        RS_IGNORE = 3'd0,
        RS_ACK    = 3'd1,
        RS_NAK    = 3'd2,
        RS_STALL  = 3'd3,
        RS_NOHS   = 3'd4
    } rsp_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } seq_state_t;

    // writable bits: endpoint 0 keeps its two host bits, the rest do not
    localparam logic [CTL_W-1:0] KEEP_EP0 = 8'hDF;
    localparam logic [CTL_W-1:0] KEEP_EPN = 8'h1F;
endpackage

// File: rtl/usbep_regfile.sv
module usbep_regfile
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int SEL_W  = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] bus_q,
    input  logic [SEL_W-1:0] tok_sel,
    output logic [4:0]       tok_q
);
    logic [CTL_W-1:0] store [NUM_EP];

    for (genvar g = 0; g < NUM_EP; g++) begin : g_word
        localparam logic [CTL_W-1:0] KEEP = (g == 0) ? KEEP_EP0 : KEEP_EPN;
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= '0;
            else if (wr && bus_sel == SEL_W'(g))
                store[g] <= wdata & KEEP;
        end
    end

    assign bus_q = store[bus_sel];
    assign tok_q = store[tok_sel][4:0];
endmodule

// File: rtl/usbep_decide.sv
module usbep_decide
    import usbep_pkg::*;
(
    input  logic      setup_off,
    input  logic      rx_on,
    input  logic      tx_on,
    input  logic      halt,
    input  logic      hs_on,
    input  tok_kind_t kind,
    input  logic      rdy,
    output rsp_t      code
);
    logic dir_ok;

    always_comb begin
        unique case (kind)
            TK_IN:           dir_ok = tx_on;
            TK_OUT, TK_SETUP: dir_ok = rx_on;
            default:         dir_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (halt && (rx_on || tx_on))
            code = RS_STALL;
        else if (kind == TK_SETUP && setup_off && rx_on && tx_on)
            code = RS_IGNORE;
        else if (!dir_ok)
            code = RS_IGNORE;
        else if (!hs_on)
            code = RS_NOHS;
        else if (rdy)
            code = RS_ACK;
        else
            code = RS_NAK;
    end
endmodule

// File: rtl/usbep_ctrl.sv
module usbep_ctrl
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int SEL_W = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             tok_valid,
    input  logic [SEL_W-1:0] tok_ep,
    input  logic [1:0]       tok_kind,
    input  logic             tok_data_rdy,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code
);
    seq_state_t       state, state_nx;
    logic [SEL_W-1:0] cap_ep;
    tok_kind_t        cap_kind;
    logic             cap_rdy;
    logic [4:0]       cap_ctl;
    rsp_t             dec_code;

    usbep_regfile #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .bus_sel (reg_sel),
        .wdata   (reg_wdata),
        .bus_q   (reg_rdata),
        .tok_sel (cap_ep),
        .tok_q   (cap_ctl)
    );

    usbep_decide decide_i (
        .setup_off (cap_ctl[4]),
        .rx_on     (cap_ctl[3]),
        .tx_on     (cap_ctl[2]),
        .halt      (cap_ctl[1]),
        .hs_on     (cap_ctl[0]),
        .kind      (cap_kind),
        .rdy       (cap_rdy),
        .code      (dec_code)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: IDLE_TO_EVAL on a token, EVAL_TO_IDLE always
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (tok_valid) state_nx = ST_EVAL;
            ST_EVAL: state_nx = ST_IDLE;
        endcase
    end

    // token capture, only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ep   <= '0;
            cap_kind <= TK_OUT;
            cap_rdy  <= 1'b0;
        end else if (state == ST_IDLE && tok_valid) begin
            cap_ep   <= tok_ep;
            cap_kind <= tok_kind_t'(tok_kind);
            cap_rdy  <= tok_data_rdy;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RS_IGNORE;
        end else begin
            rsp_valid <= (state == ST_EVAL);
            if (state == ST_EVAL) rsp_code <= dec_code;
        end
    end
endmodule

// File: rtl/usbep_checker.sv
module usbep_checker #(
    parameter int NUM_EP = 16,
    parameter int SEL_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [SEL_W-1:0] reg_sel,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             tok_valid,
    input logic             rsp_valid,
    input logic [2:0]       rsp_code
);
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tok_valid, 2));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] == 1'b0);

    assert_host_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != '0) |-> (reg_rdata[7:6] == 2'b00));

    assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_sel != $past(reg_sel)) ||
                   (reg_rdata == ($past(reg_wdata) &
                                  (($past(reg_sel) == '0) ? 8'hDF : 8'h1F))));

    assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code <= 3'd4));
endmodule

bind usbep_ctrl usbep_checker #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tok_valid (tok_valid),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code)
);

// File: tb/usbep_ctrl_tb.sv
`timescale 1ns/1ps
module usbep_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tok_valid = 1'b0;
    logic [3:0] tok_ep = '0;
    logic [1:0] tok_kind = '0;
    logic       tok_data_rdy = 1'b0;
    logic       rsp_valid;
    logic [2:0] rsp_code;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2, K_RSVD = 2'd3;
    localparam logic [2:0] C_IGN = 3'd0, C_ACK = 3'd1, C_NAK = 3'd2, C_STALL = 3'd3, C_NOHS = 3'd4;

    always #2.5 clk = ~clk;

    usbep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
        .tok_ep(tok_ep), .tok_kind(tok_kind), .tok_data_rdy(tok_data_rdy),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] sel, output logic [7:0] q);
        @(negedge clk);
        reg_sel = sel;
        #1 q = reg_rdata;
    endtask

    task automatic tok(logic [3:0] ep, logic [1:0] k, logic rdy, string req, logic [2:0] exp);
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = ep; tok_kind = k; tok_data_rdy = rdy;
        @(negedge clk);
        tok_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, rsp_valid, 1);
        chk({req, " code"}, rsp_code, exp);
        @(negedge clk);
        chk({req, " pulse"}, rsp_valid, 0);
    endtask

    task automatic t_reset;
        logic [7:0] q;
        chk("R1 rsp_valid", rsp_valid, 0);
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), q);
            chk("R1 word", q, 0);
        end
    endtask

    task automatic t_regmap;
        logic [7:0] q;
        wr(4'd0, 8'hFF);  rd(4'd0, q);  chk("R2 ep0 mask", q, 8'hDF);
        wr(4'd5, 8'hFF);  rd(4'd5, q);  chk("R2 epn mask", q, 8'h1F);
        wr(4'd15, 8'hE0); rd(4'd15, q); chk("R2 epn high", q, 8'h00);
        rd(4'd1, q);  chk("R3 neighbour", q, 8'h00);
        wr(4'd0, 8'h41);  rd(4'd0, q);  chk("R3 overwrite", q, 8'h41);
        rd(4'd5, q);  chk("R3 other kept", q, 8'h1F);
        wr(4'd0, 8'h00); wr(4'd5, 8'h00);
    endtask

    task automatic t_stall;
        wr(4'd3, 8'h0F);
        tok(4'd3, K_IN, 1'b1, "R4 in", C_STALL);
        tok(4'd3, K_SETUP, 1'b1, "R4 setup", C_STALL);
        wr(4'd3, 8'h1B);
        tok(4'd3, K_OUT, 1'b1, "R4 rx only", C_STALL);
        wr(4'd4, 8'h03);
        tok(4'd4, K_IN, 1'b1, "R5 no dir", C_IGN);
    endtask

    task automatic t_setup_block;
        wr(4'd6, 8'h1D);
        tok(4'd6, K_SETUP, 1'b1, "R6 blocked", C_IGN);
        tok(4'd6, K_OUT, 1'b1, "R6 out ok", C_ACK);
        wr(4'd6, 8'h19);
        tok(4'd6, K_SETUP, 1'b1, "R6 rx only", C_ACK);
    endtask

    task automatic t_direction;
        wr(4'd8, 8'h09);
        tok(4'd8, K_IN, 1'b1, "R7 in no tx", C_IGN);
        tok(4'd8, K_OUT, 1'b1, "R7 out rx", C_ACK);
        wr(4'd9, 8'h05);
        tok(4'd9, K_OUT, 1'b1, "R7 out no rx", C_IGN);
        tok(4'd9, K_SETUP, 1'b1, "R7 setup no rx", C_IGN);
        tok(4'd9, K_RSVD, 1'b1, "R7 rsvd kind", C_IGN);
    endtask

    task automatic t_handshake;
        wr(4'd10, 8'h0C);
        tok(4'd10, K_IN, 1'b1, "R8 rdy", C_NOHS);
        tok(4'd10, K_OUT, 1'b0, "R8 not rdy", C_NOHS);
        wr(4'd11, 8'h0D);
        tok(4'd11, K_IN, 1'b0, "R9 nak", C_NAK);
        tok(4'd11, K_IN, 1'b1, "R9 ack", C_ACK);
    endtask

    task automatic t_busy;
        // ep12 answers ACK, ep13 would answer STALL; the second token is dropped
        wr(4'd12, 8'h0D); wr(4'd13, 8'h0F);
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = 4'd12; tok_kind = K_IN; tok_data_rdy = 1'b1;
        @(negedge clk);
        tok_ep = 4'd13;
        chk("R10 not early", rsp_valid, 0);
        @(negedge clk);
        tok_valid = 1'b0;
        chk("R10 valid", rsp_valid, 1);
        chk("R10 first kept", rsp_code, C_ACK);
        @(negedge clk);
        chk("R10 second dropped", rsp_valid, 0);
        @(negedge clk);
        chk("R10 still idle", rsp_valid, 0);
    endtask

    task automatic t_persist;
        wr(4'd7, 8'h0F);
        tok(4'd7, K_IN, 1'b1, "R11 first", C_STALL);
        tok(4'd7, K_IN, 1'b1, "R11 second", C_STALL);
        tok(4'd7, K_OUT, 1'b1, "R11 third", C_STALL);
        wr(4'd7, 8'h0D);
        tok(4'd7, K_IN, 1'b1, "R11 cleared", C_ACK);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_stall();
        t_setup_block();
        t_direction();
        t_handshake();
        t_busy();
        t_persist();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule